// File: doc/BRIEF.md
# Frame-Snapshot Register Target on a Two-Wire Bus

This block is the host-facing side of a display timing analyser. A set of measurement engines elsewhere on the chip measures line and field timing. The results cover the sync width, the sync period, the first and last active-video positions and the flyback edges, together with two sync polarity flags. This block copies all of those results into a shadow bank when it sees the field-start strobe. A microcontroller then reads the bank over a standard I2C bus at its own pace. Each result is presented as a two-byte pair. A 12-bit count sits left-justified in the pair with a zeroed low nibble. An 8-bit width fills the upper byte, and the lower byte of its pair reads zero.

The target has a fixed 7-bit address. A write transaction first sets a byte pointer and may then store data at that pointer. A read transaction returns bytes from the pointer and advances the pointer after each byte. The only writable location is a clock-multiplier setting in the range 1 to 8, which is driven straight out to the clock generator. A field strobe that arrives while a read transaction is open is held back until that transaction closes. This keeps any multi-byte read coherent. Both bus lines pass through a synchroniser and a glitch filter before the bus state machine sees them.

Top module: `asz_snapshot_i2c`

## Requirements
- R1: The target answers only to the 7-bit address 0x3A, which gives byte 0x74 for a write and 0x75 for a read. It pulls SDA low for the acknowledge bit after a matching address byte and leaves SDA released after any other address byte.
- R2: Register layout, in byte-pointer order. Pairs at 0x00/0x01 hold the vertical sync width, first video line, last video line and field period. The horizontal sync width, first and last video clock follow, then the flyback start, flyback stop and line period, ending at 0x12/0x13. The even address of each pair is the upper byte. A 12-bit value V reads as {V, 4'b0000}. An 8-bit width W reads as W followed by 0x00.
- R3: During a read, the pointer advances by one after each byte, so a burst returns consecutive locations. Pointers 0x16 and above read 0x00.
- R4: All shadow values load in the same clock cycle from the measurement inputs presented with a one-cycle `frame_strobe`. Input changes without a strobe are not visible on the bus.
- R5: A strobe seen while a read transaction is open does not alter the shadow bank. The values captured at that strobe are loaded once a STOP or a new START ends the read.
- R6: The multiplier byte at 0x14 holds the setting in bits 3:0 and reads zero in bits 7:4. It resets to 2. A written value of 1 to 8 is taken and appears on `clk_mult`. Any other written value leaves the setting unchanged.
- R7: Writes to pointers 0x00 to 0x13 and 0x15 change nothing that can be read back.
- R8: The status byte at 0x15 carries the horizontal polarity in bit 1 and the vertical polarity in bit 0. A bit is 0 for a positive sync (duty below 50 %) and 1 for a negative sync. Bits 7:2 read 0.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` clock cycles (default 3, which is 60 ns at 50 MHz) has no effect on the bus state.
- R10: The pointer also advances after each written data byte, so one write transaction can store consecutive locations.
- R11: When the host does not acknowledge a read byte, the target releases SDA and sends no further data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| frame_strobe | input | 1 | One-cycle pulse at the field-sync leading edge |
| v_width_i | input | 8 | Vertical sync width in lines |
| v_first_i | input | 12 | First line with active video |
| v_last_i | input | 12 | Last line with active video |
| v_period_i | input | 12 | Field period in lines |
| h_width_i | input | 8 | Horizontal sync width in clocks |
| h_first_i | input | 12 | First active-video clock in a line |
| h_last_i | input | 12 | Last active-video clock in a line |
| fb_start_i | input | 12 | Flyback pulse start in clocks |
| fb_stop_i | input | 12 | Flyback pulse end in clocks |
| h_period_i | input | 12 | Line period in clocks |
| h_neg_i | input | 1 | Horizontal sync is negative |
| v_neg_i | input | 1 | Vertical sync is negative |
| clk_mult | output | 4 | Clock multiplier setting, 1 to 8 |

## Verification
The assertions check four properties on every cycle:
- the multiplier never leaves 1..8 and changes only after a decoded write;
- the shadow bank holds still while a read is open;
- a held-back strobe is applied as soon as the read closes;
- SDA is released after a STOP.

The bench's bus scenarios are the only evidence for the remaining behaviour. These cover the byte layout and the polarity status, the pointer advance in both directions, and the address filtering. They also cover whether a strobe inside a read yields the old field during the read and the captured field after it, and whether glitches are rejected inside a live transfer.

// File: rtl/asz_pkg.sv
package asz_pkg;
  localparam int MEAS_W   = 12;
  localparam int WID_W    = 8;
  localparam int PAIR_W   = 16;
  localparam int NUM_PAIR = 10;
  localparam logic [7:0] MULT_ADDR = 8'h14;
  localparam logic [7:0] STAT_ADDR = 8'h15;
  localparam logic [3:0] MULT_RST  = 4'd2;
  localparam logic [7:0] MULT_MIN  = 8'd1;
  localparam logic [7:0] MULT_MAX  = 8'd8;

  typedef struct packed {
    logic [WID_W-1:0]  v_wid;
    logic [MEAS_W-1:0] v_first;
    logic [MEAS_W-1:0] v_last;
    logic [MEAS_W-1:0] v_per;
    logic [WID_W-1:0]  h_wid;
    logic [MEAS_W-1:0] h_first;
    logic [MEAS_W-1:0] h_last;
    logic [MEAS_W-1:0] fb_start;
    logic [MEAS_W-1:0] fb_stop;
    logic [MEAS_W-1:0] h_per;
    logic              h_neg;
    logic              v_neg;
  } meas_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_SUB, S_SACK, S_WR, S_WACK, S_RD, S_RACK
  } bus_st_t;
endpackage

// File: rtl/asz_glitch_filter.sv
module asz_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   out_q, out_d;
  logic                   smp;

  assign smp  = sync_q[SYNC_STAGES-1];
  assign dout = out_q;

  // the output follows the sample only after FILT_CYC agreeing samples in a row
  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (smp != out_q) begin
      if (cnt_q == CW'(FILT_CYC - 1)) out_d = smp;
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end
endmodule

// File: rtl/asz_bus_fsm.sv
module asz_bus_fsm import asz_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic [7:0] rd_byte,
  output logic [7:0] ptr,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_busy,
  output logic       stop_evt
);
  bus_st_t    st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d, tx_q, tx_d, ptr_q, ptr_d;
  logic [7:0] wa_q, wa_d, wd_q, wd_d;
  logic       oe_q, oe_d, rdb_q, rdb_d, nack_q, nack_d, we_q, we_d;
  logic       scl_q, sda_q;
  logic       rise, fall, start_c, stop_c;

  assign rise    =  scl & ~scl_q;
  assign fall    = ~scl &  scl_q;
  assign start_c =  scl & scl_q & sda_q & ~sda;
  assign stop_c  =  scl & scl_q & ~sda_q & sda;

  assign ptr      = ptr_q;
  assign sda_oe   = oe_q;
  assign wr_en    = we_q;
  assign wr_addr  = wa_q;
  assign wr_data  = wd_q;
  assign rd_busy  = rdb_q;
  assign stop_evt = stop_c;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    ptr_d  = ptr_q;
    oe_d   = oe_q;
    rdb_d  = rdb_q;
    nack_d = nack_q;
    we_d   = 1'b0;
    wa_d   = wa_q;
    wd_d   = wd_q;
    if (start_c) begin
      st_d  = S_ADDR;
      cnt_d = 4'd0;
      oe_d  = 1'b0;
      rdb_d = 1'b0;
    end else if (stop_c) begin
      st_d  = S_IDLE;
      oe_d  = 1'b0;
      rdb_d = 1'b0;
    end else begin
      unique case (st_q)
        S_ADDR, S_SUB, S_WR: begin
          if (rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda};
            cnt_d = cnt_q + 4'd1;
          end else if (fall && cnt_q == 4'd8) begin
            if (st_q == S_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                oe_d  = 1'b1;
                rdb_d = sh_q[0];
                st_d  = S_AACK;
              end else begin
                st_d  = S_IDLE;
              end
            end else if (st_q == S_SUB) begin
              ptr_d = sh_q;
              oe_d  = 1'b1;
              st_d  = S_SACK;
            end else begin
              we_d  = 1'b1;
              wa_d  = ptr_q;
              wd_d  = sh_q;
              ptr_d = ptr_q + 8'd1;
              oe_d  = 1'b1;
              st_d  = S_WACK;
            end
          end
        end
        S_SACK, S_WACK: begin
          if (fall) begin
            oe_d  = 1'b0;
            cnt_d = 4'd0;
            st_d  = S_WR;
          end
        end
        S_AACK, S_RACK: begin
          if (rise) nack_d = sda;
          if (fall) begin
            if (st_q == S_AACK && !rdb_q) begin
              oe_d  = 1'b0;
              cnt_d = 4'd0;
              st_d  = S_SUB;
            end else if (st_q == S_RACK && nack_q) begin
              oe_d  = 1'b0;
              st_d  = S_IDLE;
            end else begin
              tx_d  = rd_byte;
              oe_d  = ~rd_byte[7];
              ptr_d = ptr_q + 8'd1;
              cnt_d = 4'd1;
              st_d  = S_RD;
            end
          end
        end
        S_RD: begin
          if (fall) begin
            if (cnt_q == 4'd8) begin
              oe_d = 1'b0;
              st_d = S_RACK;
            end else begin
              oe_d  = ~tx_q[6];
              tx_d  = {tx_q[6:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= 4'd0;
      sh_q   <= 8'd0;
      tx_q   <= 8'd0;
      ptr_q  <= 8'd0;
      oe_q   <= 1'b0;
      rdb_q  <= 1'b0;
      nack_q <= 1'b1;
      we_q   <= 1'b0;
      wa_q   <= 8'd0;
      wd_q   <= 8'd0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      ptr_q  <= ptr_d;
      oe_q   <= oe_d;
      rdb_q  <= rdb_d;
      nack_q <= nack_d;
      we_q   <= we_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
      scl_q  <= scl;
      sda_q  <= sda;
    end
  end
endmodule

// File: rtl/asz_snap_regs.sv
module asz_snap_regs import asz_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  meas_t      meas_i,
  input  logic       frame_strobe,
  input  logic       rd_busy,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [3:0] clk_mult,
  output logic       pend,
  output meas_t      snap
);
  meas_t       stage_q, stage_d, snap_q, snap_d;
  logic        pend_q, pend_d;
  logic [3:0]  mult_q, mult_d;
  logic [PAIR_W-1:0] pairs [16];

  assign snap     = snap_q;
  assign pend     = pend_q;
  assign clk_mult = mult_q;

  // strobe captures into the stage; the stage reaches the bank once no read is open
  always_comb begin
    stage_d = frame_strobe ? meas_i : stage_q;
    snap_d  = snap_q;
    pend_d  = pend_q;
    if (frame_strobe && !rd_busy) begin
      snap_d = meas_i;
      pend_d = 1'b0;
    end else if (frame_strobe) begin
      pend_d = 1'b1;
    end else if (pend_q && !rd_busy) begin
      snap_d = stage_q;
      pend_d = 1'b0;
    end
  end

  always_comb begin
    mult_d = mult_q;
    if (wr_en && wr_addr == MULT_ADDR && wr_data >= MULT_MIN && wr_data <= MULT_MAX)
      mult_d = wr_data[3:0];
  end

  always_comb begin
    for (int i = 0; i < 16; i++) pairs[i] = '0;
    pairs[0] = {snap_q.v_wid,    {(PAIR_W-WID_W){1'b0}}};
    pairs[1] = {snap_q.v_first,  {(PAIR_W-MEAS_W){1'b0}}};
    pairs[2] = {snap_q.v_last,   {(PAIR_W-MEAS_W){1'b0}}};
    pairs[3] = {snap_q.v_per,    {(PAIR_W-MEAS_W){1'b0}}};
    pairs[4] = {snap_q.h_wid,    {(PAIR_W-WID_W){1'b0}}};
    pairs[5] = {snap_q.h_first,  {(PAIR_W-MEAS_W){1'b0}}};
    pairs[6] = {snap_q.h_last,   {(PAIR_W-MEAS_W){1'b0}}};
    pairs[7] = {snap_q.fb_start, {(PAIR_W-MEAS_W){1'b0}}};
    pairs[8] = {snap_q.fb_stop,  {(PAIR_W-MEAS_W){1'b0}}};
    pairs[9] = {snap_q.h_per,    {(PAIR_W-MEAS_W){1'b0}}};
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr < 8'(2 * NUM_PAIR))
      rd_data = rd_addr[0] ? pairs[rd_addr[4:1]][7:0] : pairs[rd_addr[4:1]][15:8];
    else if (rd_addr == MULT_ADDR)
      rd_data = {4'b0000, mult_q};
    else if (rd_addr == STAT_ADDR)
      rd_data = {6'b000000, snap_q.h_neg, snap_q.v_neg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      snap_q  <= '0;
      pend_q  <= 1'b0;
      mult_q  <= MULT_RST;
    end else begin
      stage_q <= stage_d;
      snap_q  <= snap_d;
      pend_q  <= pend_d;
      mult_q  <= mult_d;
    end
  end
endmodule

// File: rtl/asz_snapshot_i2c.sv
module asz_snapshot_i2c import asz_pkg::*; #(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              frame_strobe,
  input  logic [WID_W-1:0]  v_width_i,
  input  logic [MEAS_W-1:0] v_first_i,
  input  logic [MEAS_W-1:0] v_last_i,
  input  logic [MEAS_W-1:0] v_period_i,
  input  logic [WID_W-1:0]  h_width_i,
  input  logic [MEAS_W-1:0] h_first_i,
  input  logic [MEAS_W-1:0] h_last_i,
  input  logic [MEAS_W-1:0] fb_start_i,
  input  logic [MEAS_W-1:0] fb_stop_i,
  input  logic [MEAS_W-1:0] h_period_i,
  input  logic              h_neg_i,
  input  logic              v_neg_i,
  output logic [3:0]        clk_mult
);
  localparam int NLINES = 2;

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic [NLINES-1:0] line_raw, line_flt;
  logic [7:0]        ptr, rd_byte, wr_addr, wr_data;
  logic              wr_en, rd_busy, stop_evt, snap_pend;
  meas_t             meas, snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_flt
    asz_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_sync_n), .din(line_raw[g]), .dout(line_flt[g]));
  end

  assign meas = '{v_wid: v_width_i, v_first: v_first_i, v_last: v_last_i,
                  v_per: v_period_i, h_wid: h_width_i, h_first: h_first_i,
                  h_last: h_last_i, fb_start: fb_start_i, fb_stop: fb_stop_i,
                  h_per: h_period_i, h_neg: h_neg_i, v_neg: v_neg_i};

  asz_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .scl(line_flt[0]), .sda(line_flt[1]),
    .rd_byte(rd_byte), .ptr(ptr), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_busy(rd_busy), .stop_evt(stop_evt));

  asz_snap_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .meas_i(meas), .frame_strobe(frame_strobe),
    .rd_busy(rd_busy), .rd_addr(ptr), .rd_data(rd_byte), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .clk_mult(clk_mult),
    .pend(snap_pend), .snap(snap_q));
endmodule

// File: rtl/asz_snap_chk.sv
module asz_snap_chk import asz_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic [3:0] clk_mult,
  input logic       rd_busy,
  input logic       pend,
  input logic       stop_evt,
  input logic       wr_en,
  input meas_t      snap
);
  p_mult_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_mult >= 4'd1 && clk_mult <= 4'd8);

  p_mult_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_mult) |-> $past(wr_en));

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> $stable(snap));

  p_pend_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !rd_busy) |=> !pend);

  p_release_on_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

bind asz_snapshot_i2c asz_snap_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sda_oe(sda_oe), .clk_mult(clk_mult),
  .rd_busy(rd_busy), .pend(snap_pend), .stop_evt(stop_evt), .wr_en(wr_en),
  .snap(snap_q));

// File: tb/tb_asz_snapshot_i2c.sv
`timescale 1ns/1ps
module tb_asz_snapshot_i2c;
  typedef struct packed {
    logic [7:0]  vw; logic [11:0] vf; logic [11:0] vl; logic [11:0] vp;
    logic [7:0]  hw; logic [11:0] hf; logic [11:0] hl; logic [11:0] fs;
    logic [11:0] fe; logic [11:0] hp; logic hn; logic vn;
  } fr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_d = 1'b1, sda_d = 1'b1, strobe = 1'b0;
  logic sda_oe, sda_ln;
  logic [3:0] clk_mult;
  fr_t drv, exp_f;
  logic [3:0] e_mult;
  logic [7:0] rbuf [32];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_ln = sda_d & ~sda_oe;

  asz_snapshot_i2c dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_d), .sda_i(sda_ln), .sda_oe(sda_oe),
    .frame_strobe(strobe), .v_width_i(drv.vw), .v_first_i(drv.vf),
    .v_last_i(drv.vl), .v_period_i(drv.vp), .h_width_i(drv.hw),
    .h_first_i(drv.hf), .h_last_i(drv.hl), .fb_start_i(drv.fs),
    .fb_stop_i(drv.fe), .h_period_i(drv.hp), .h_neg_i(drv.hn),
    .v_neg_i(drv.vn), .clk_mult(clk_mult));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] a);
    logic [15:0] p;
    case (a[7:1])
      7'd0: p = {exp_f.vw, 8'h00};
      7'd1: p = {exp_f.vf, 4'h0};
      7'd2: p = {exp_f.vl, 4'h0};
      7'd3: p = {exp_f.vp, 4'h0};
      7'd4: p = {exp_f.hw, 8'h00};
      7'd5: p = {exp_f.hf, 4'h0};
      7'd6: p = {exp_f.hl, 4'h0};
      7'd7: p = {exp_f.fs, 4'h0};
      7'd8: p = {exp_f.fe, 4'h0};
      7'd9: p = {exp_f.hp, 4'h0};
      default: p = 16'h0;
    endcase
    if (a < 8'h14)       return a[0] ? p[7:0] : p[15:8];
    else if (a == 8'h14) return {4'h0, e_mult};
    else if (a == 8'h15) return {6'b0, exp_f.hn, exp_f.vn};
    return 8'h00;
  endfunction

  function automatic fr_t rnd_frame();
    fr_t f;
    f = fr_t'({$urandom, $urandom, $urandom, $urandom});
    return f;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wt(8); sda_d = b; wt(8); scl_d = 1'b1; wt(16); scl_d = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    sda_d = 1'b1; wt(16); scl_d = 1'b1; wt(8); b = sda_ln; wt(8); scl_d = 1'b0;
  endtask

  task automatic i2c_start();
    sda_d = 1'b1; wt(8); scl_d = 1'b1; wt(16); sda_d = 1'b0; wt(16); scl_d = 1'b0;
  endtask

  task automatic i2c_stop();
    sda_d = 1'b0; wt(8); scl_d = 1'b1; wt(16); sda_d = 1'b1; wt(16);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = ~b;
  endtask

  // kind 1: short SCL pulse in the low phase; kind 2: short SDA inversion in the high phase
  task automatic send_glitch(input logic [7:0] v, input int gi, input int kind, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      wt(8); sda_d = v[i];
      if (i == gi && kind == 1) begin wt(3); scl_d = 1'b1; wt(2); scl_d = 1'b0; wt(3); end
      else wt(8);
      scl_d = 1'b1;
      if (i == gi && kind == 2) begin wt(6); sda_d = ~v[i]; wt(2); sda_d = v[i]; wt(8); end
      else wt(16);
      scl_d = 1'b0;
    end
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(~ack);
  endtask

  task automatic read_regs(input logic [7:0] a, input int n);
    logic k;
    i2c_start(); send_byte(8'h74, k); send_byte(a, k);
    i2c_start(); send_byte(8'h75, k);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    logic k;
    i2c_start(); send_byte(8'h74, k); send_byte(a, k); send_byte(d, k); i2c_stop();
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; wt(1); strobe = 1'b0; wt(1);
  endtask

  task automatic new_frame(input fr_t f);
    drv = f; wt(1); pulse_strobe(); exp_f = f;
  endtask

  task automatic check_all(input string tag);
    read_regs(8'h00, 22);
    for (int i = 0; i < 22; i++) chk(tag, rbuf[i], exp_byte(8'(i)));
  endtask

  initial begin
    logic k;
    logic [7:0] v;
    fr_t saved, held;
    void'($urandom(32'd20250611));
    drv = '0; exp_f = '0; e_mult = 4'd2;
    wt(4); rst_n = 1'b1; wt(6);

    // R6 reset value, bus released
    chk("R6 reset multiplier", {4'h0, clk_mult}, 8'h02);
    chk("R1 released after reset", {7'h0, sda_oe}, 8'h00);

    // R1 address match
    i2c_start(); send_byte(8'h50, k); i2c_stop();
    chk("R1 foreign address ignored", {7'h0, k}, 8'h00);
    i2c_start(); send_byte(8'h74, k); i2c_stop();
    chk("R1 own address acknowledged", {7'h0, k}, 8'h01);

    // R2 R3 R8 directed extremes, then random frames
    new_frame('1); check_all("R2 R8 all ones");
    new_frame('0); check_all("R2 R8 all zeros");
    for (int it = 0; it < 3; it++) begin
      new_frame(rnd_frame());
      check_all("R2 R3 R8 random frame");
    end

    // R4 input changes without strobe stay invisible
    drv = rnd_frame(); wt(4);
    read_regs(8'h02, 6);
    for (int i = 0; i < 6; i++) chk("R4 no strobe no update", rbuf[i], exp_byte(8'(i + 2)));

    // R3 burst past the end
    read_regs(8'h13, 5);
    for (int i = 0; i < 5; i++) chk("R3 burst tail", rbuf[i], exp_byte(8'(i + 8'h13)));

    // R6 multiplier writes
    write_reg(8'h14, 8'h06); e_mult = 4'd6;
    chk("R6 accept 6", {4'h0, clk_mult}, 8'h06);
    write_reg(8'h14, 8'h00);
    chk("R6 reject 0", {4'h0, clk_mult}, 8'h06);
    write_reg(8'h14, 8'h09);
    chk("R6 reject 9", {4'h0, clk_mult}, 8'h06);
    write_reg(8'h14, 8'h08); e_mult = 4'd8;
    chk("R6 accept 8", {4'h0, clk_mult}, 8'h08);

    // R7 read-only locations, R10 write pointer advance
    write_reg(8'h02, 8'h5A);
    write_reg(8'h15, 8'hFF);
    i2c_start(); send_byte(8'h74, k); send_byte(8'h13, k);
    send_byte(8'hC3, k); send_byte(8'h03, k); i2c_stop();
    e_mult = 4'd3;
    chk("R10 second write byte lands at 0x14", {4'h0, clk_mult}, 8'h03);
    read_regs(8'h00, 22);
    for (int i = 0; i < 22; i++) chk("R7 read-only unchanged", rbuf[i], exp_byte(8'(i)));

    // R5 strobe during an open read
    saved = exp_f;
    i2c_start(); send_byte(8'h74, k); send_byte(8'h00, k);
    i2c_start(); send_byte(8'h75, k);
    recv_byte(1'b1, rbuf[0]);
    held = rnd_frame(); drv = held; wt(1); pulse_strobe();
    drv = rnd_frame(); wt(2);
    for (int i = 1; i < 6; i++) recv_byte(i != 5, rbuf[i]);
    i2c_stop();
    for (int i = 0; i < 6; i++) chk("R5 old field during read", rbuf[i], exp_byte(8'(i)));
    exp_f = held;
    check_all("R5 captured field after read");
    if (saved == held) $display("note: identical frames drawn");

    // R11 NACK releases the line (next location would start with a 0 bit)
    i2c_start(); send_byte(8'h74, k); send_byte(8'h16, k);
    i2c_start(); send_byte(8'h75, k);
    recv_byte(1'b0, v);
    wt(12);
    chk("R11 released after NACK", {7'h0, sda_oe}, 8'h00);
    chk("R3 beyond map", v, 8'h00);
    i2c_stop();

    // R9 glitch rejection inside live transfers
    i2c_start(); send_byte(8'h74, k); send_byte(8'h14, k);
    send_glitch(8'h05, 2, 1, k); i2c_stop();
    chk("R9 SCL spike rejected", {4'h0, clk_mult}, 8'h05);
    i2c_start(); send_byte(8'h74, k); send_byte(8'h14, k);
    send_glitch(8'h08, 3, 2, k); i2c_stop();
    chk("R9 SDA spike rejected", {4'h0, clk_mult}, 8'h08);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected below 180000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule